// File: doc/BRIEF.md
# Compare-match timer channel

A single timer channel for a memory-mapped peripheral. An up-counter advances on a rate derived from a slow reference clock. The reference clock reaches the block as a one-cycle pulse in the bus clock domain, and a prescaler divides it by 1, 8, 32 or 128. Software sets a compare value. When the counter reaches it, a match flag is raised. In restart mode the counter also goes back to zero, so the period is compare+1 counts. An overflow flag records a roll from all ones to zero that is not a compare match. An interrupt request is raised while the match flag is set, the enable bit is on and the request type selects an interrupt.

A start/stop register is shared among several channels and holds one run bit per channel. This channel counts only while the bit at its own index is 1. A write to the counter does not reach the counting logic at once. It is committed on the second reference pulse after the write, and reads return the old value until then. Flags are cleared by writing 0 to them, so a read-modify-write that masks only the flags clears them.

Top module: `cmatch_timer`

## Requirements
- R1: Word address 0 is the control/status word, 1 the counter, 2 the compare value and 3 the start/stop register. In the control word, bit 15 is the match flag, 14 the overflow flag, 8 restart mode, 7 the interrupt enable, 5:4 the request type and 2:0 the clock select. All other control bits read 0.
- R2: In restart mode (bit 8 = 1), a count event with counter equal to compare loads zero and sets the match flag, so one period is compare+1 counts.
- R3: In free-run mode (bit 8 = 0), a count event with counter equal to compare sets the match flag and the counter still increments.
- R4: The overflow flag is set when a count event takes the counter from all ones to zero without a compare match.
- R5: Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. A count event that sets a flag wins over a clearing write in the same cycle.
- R6: Clock select 4 counts once per 8 reference pulses, 5 once per 32, 6 once per 128 and 7 on every pulse. Codes 0 to 3 never count. The prescaler is held at zero while the channel is stopped.
- R7: The start/stop register is STR_W bits wide and fully readable and writable. The counter advances only while bit RUN_IDX (default 0) is 1. The other bits have no effect on this channel.
- R8: A counter write is committed on the second reference pulse after it. Until then, reads return the old value. A new write restarts the wait.
- R9: The irq output is 1 exactly while the match flag is 1, bit 7 is 1 and the request type equals 2. Writing 0 to the control word drops it.
- R10: After reset, the control word and counter read 0, the compare value reads all ones, the start/stop register reads 0 and irq is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | One-cycle pulse per reference clock period |
| addr | input | 2 | Register word address |
| wr_en | input | 1 | Write strobe |
| wdata | input | CNT_W | Write data |
| rdata | output | CNT_W | Read data for addr (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
Some behaviours are checked by assertions on every cycle:
- In restart mode the counter returns to zero after a match.
- In free-run mode the counter increments through a match.
- The overflow flag rises only on a roll from all ones to zero.
- A clearing write takes a flag down unless a count event sets it in the same cycle.
- A stopped channel holds its counter.
- A pending counter write lands exactly when it commits.
- A zero control write drops irq.

Other behaviours show only in the bench's scenarios:
- The divisor of each clock-select code, measured as the count after a given number of reference pulses.
- The delayed read-back of a counter write.
- The readback layout of the control word.
- The run bit's index within the shared register.

// File: rtl/cmatch_timer.sv
module cmatch_timer #(
  parameter int CNT_W   = 32,
  parameter int STR_W   = 8,
  parameter int RUN_IDX = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_tick,
  input  logic [1:0]       addr,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             irq
);
  localparam int PRE_W = 7;
  localparam logic [1:0] REQ_IRQ = 2'd2;

  logic [CNT_W-1:0] cnt_q, cmp_q, pend_val;
  logic [STR_W-1:0] str_q;
  logic [PRE_W-1:0] pre_q, pre_last;
  logic [1:0]       pend_n, req_q;
  logic [2:0]       cks_q;
  logic             mf_q, ovf_q, restart_q, ie_q;
  logic             run, div_ok, cnt_en, commit, hit, at_top, set_m, set_o;
  logic             wr_ctl, wr_cnt, wr_cmp, wr_str;

  assign run    = str_q[RUN_IDX];
  assign wr_ctl = wr_en && addr == 2'd0;
  assign wr_cnt = wr_en && addr == 2'd1;
  assign wr_cmp = wr_en && addr == 2'd2;
  assign wr_str = wr_en && addr == 2'd3;

  always_comb begin
    div_ok   = cks_q[2];
    case (cks_q)
      3'd4:    pre_last = PRE_W'(7);
      3'd5:    pre_last = PRE_W'(31);
      3'd6:    pre_last = PRE_W'(127);
      default: pre_last = '0;
    endcase
  end

  assign cnt_en = ref_tick && run && div_ok && (pre_q >= pre_last);
  assign commit = ref_tick && pend_n == 2'd1;
  assign hit    = cnt_q == cmp_q;
  assign at_top = cnt_q == {CNT_W{1'b1}};
  assign set_m  = cnt_en && !commit && hit;
  assign set_o  = cnt_en && !commit && at_top && !hit;
  assign irq    = mf_q && ie_q && req_q == REQ_IRQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else if (!run) pre_q <= '0;
    else if (ref_tick && div_ok) pre_q <= (pre_q >= pre_last) ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_val <= '0;
      pend_n   <= '0;
    end else if (wr_cnt) begin
      pend_val <= wdata;
      pend_n   <= 2'd2;
    end else if (ref_tick && pend_n != 2'd0) begin
      pend_n   <= pend_n - 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (commit) cnt_q <= pend_val;
    else if (cnt_en) cnt_q <= (hit && restart_q) ? '0 : cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q <= '1;
      str_q <= '0;
    end else begin
      if (wr_cmp) cmp_q <= wdata;
      if (wr_str) str_q <= wdata[STR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mf_q <= 1'b0; ovf_q <= 1'b0; restart_q <= 1'b0;
      ie_q <= 1'b0; req_q <= '0;   cks_q <= '0;
    end else begin
      if (wr_ctl) begin
        mf_q      <= mf_q & wdata[15];
        ovf_q     <= ovf_q & wdata[14];
        restart_q <= wdata[8];
        ie_q      <= wdata[7];
        req_q     <= wdata[5:4];
        cks_q     <= wdata[2:0];
      end
      if (set_m) mf_q  <= 1'b1;
      if (set_o) ovf_q <= 1'b1;
    end
  end

  always_comb begin
    case (addr)
      2'd0:    rdata = CNT_W'({mf_q, ovf_q, 5'b0, restart_q, ie_q, 1'b0, req_q, 1'b0, cks_q});
      2'd1:    rdata = cnt_q;
      2'd2:    rdata = cmp_q;
      default: rdata = CNT_W'(str_q);
    endcase
  end

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (cnt_en && hit && restart_q && !commit) |=> (cnt_q == '0 && mf_q)); // R2
  AST_FREE_PASS: assert property (@(posedge clk) disable iff (!rst_n) (cnt_en && hit && !restart_q && !commit) |=> (cnt_q == $past(cnt_q) + CNT_W'(1) && mf_q)); // R3
  AST_OVF_ROLL: assert property (@(posedge clk) disable iff (!rst_n) $rose(ovf_q) |-> ($past(cnt_q) == {CNT_W{1'b1}} && cnt_q == '0)); // R4
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctl && !wdata[15] && !(cnt_en && hit && !commit)) |=> !mf_q); // R5
  AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!run && !commit) |=> $stable(cnt_q)); // R7
  AST_PEND_ARM: assert property (@(posedge clk) disable iff (!rst_n) wr_cnt |=> pend_n == 2'd2); // R8
  AST_COMMIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) commit |=> cnt_q == $past(pend_val)); // R8
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (!rst_n) (wr_ctl && wdata[15:0] == 16'h0) |=> !irq); // R9
endmodule

// File: tb/cmatch_timer_tb.sv
module cmatch_timer_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0, ref_tick = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  cmatch_timer dut_i (.clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .addr(addr),
                      .wr_en(wr_en), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #10 clk = ~clk;

  function automatic int div_of(input int cks);
    case (cks)
      4: return 8;
      5: return 32;
      6: return 128;
      default: return 1;
    endcase
  endfunction

  function automatic logic [31:0] exp_cnt(input int k, input int c);
    return 32'(k % (c + 1));
  endfunction

  function automatic logic exp_mf(input int k, input int c);
    return k >= c + 1;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1'b1;
      @(negedge clk); ref_tick = 1'b0;
    end
  endtask

  task automatic load_cnt(input logic [31:0] v);
    wr(3, 0); wr(1, v); tick(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    rd(0, d); check("R10 ctl", d, 32'h0);
    rd(1, d); check("R10 cnt", d, 32'h0);
    rd(2, d); check("R10 cmp", d, 32'hFFFF_FFFF);
    rd(3, d); check("R10 str", d, 32'h0);
    check("R10 irq", {31'b0, irq}, 32'h0);

    // R1 unused control bits read 0, flags cannot be set by software
    wr(0, 32'h0000_FFFF); rd(0, d); check("R1 ctl layout", d, 32'h0000_01B7);
    wr(2, 32'h0000_1234); rd(2, d); check("R1 cmp", d, 32'h0000_1234);
    wr(0, 0);

    // R8 delayed counter write, restart on rewrite
    wr(1, 32'h0000_0011); tick(1);
    wr(1, 32'h0000_0022); tick(1);
    rd(1, d); check("R8 old value held", d, 32'h0);
    tick(1); rd(1, d); check("R8 committed", d, 32'h0000_0022);

    // R7 only run bit RUN_IDX starts the channel
    load_cnt(0); wr(0, 32'h0000_0007);
    wr(3, 32'h0000_00FE); tick(5);
    rd(3, d); check("R7 str readback", d, 32'h0000_00FE);
    rd(1, d); check("R7 other bits no effect", d, 32'h0);
    wr(3, 32'h0000_0001); tick(3); wr(3, 0);
    rd(1, d); check("R7 run bit counts", d, 32'h3);

    // R6 reserved clock select never counts
    load_cnt(0); wr(0, 32'h0000_0000); wr(3, 1); tick(10); wr(3, 0);
    rd(1, d); check("R6 reserved code", d, 32'h0);

    // R3 free-run passes the compare value
    load_cnt(0); wr(2, 2); wr(0, 32'h0000_0007); wr(3, 1); tick(5); wr(3, 0);
    rd(1, d); check("R3 free-run cnt", d, 32'h5);
    rd(0, d); check("R3 match flag", d, 32'h0000_8007);

    // R5 write 1 keeps, write 0 clears
    wr(0, 32'h0000_8007); rd(0, d); check("R5 write one keeps", d, 32'h0000_8007);
    wr(0, 32'h0000_0007); rd(0, d); check("R5 write zero clears", d, 32'h0000_0007);

    // R4 overflow without match
    load_cnt(32'hFFFF_FFFF); rd(1, d); check("R8 all ones loaded", d, 32'hFFFF_FFFF);
    wr(2, 5); wr(0, 32'h0000_0007); wr(3, 1); tick(1); wr(3, 0);
    rd(1, d); check("R4 roll to zero", d, 32'h0);
    rd(0, d); check("R4 overflow flag", d, 32'h0000_4007);

    // R2 restart at compare all ones: match, no overflow
    load_cnt(32'hFFFF_FFFF); wr(2, 32'hFFFF_FFFF); wr(0, 32'h0000_0107);
    wr(3, 1); tick(1); wr(3, 0);
    rd(1, d); check("R2 restart to zero", d, 32'h0);
    rd(0, d); check("R2 match not overflow", d, 32'h0000_8107);

    // R9 irq gating
    load_cnt(0); wr(2, 1); wr(0, 32'h0000_01A7); wr(3, 1); tick(2); wr(3, 0);
    check("R9 irq raised", {31'b0, irq}, 32'h1);
    wr(0, 32'h0000_8197); check("R9 req type 1 no irq", {31'b0, irq}, 32'h0);
    wr(0, 32'h0000_81A7); check("R9 irq back", {31'b0, irq}, 32'h1);
    wr(0, 32'h0); check("R9 zero write drops irq", {31'b0, irq}, 32'h0);
    rd(0, d); check("R9 ctl cleared", d, 32'h0);

    // R2 R6 random trials
    for (int t = 0; t < 40; t++) begin
      int cks, c, n, k;
      cks = 4 + int'($urandom % 4);
      c   = int'($urandom % 20);
      n   = int'($urandom % 400);
      k   = n / div_of(cks);
      load_cnt(0); wr(2, 32'(c));
      wr(0, 32'h0000_01A0 | 32'(cks)); wr(3, 1); tick(n); wr(3, 0);
      rd(1, d); check("R6 R2 random cnt", d, exp_cnt(k, c));
      rd(0, d); check("R2 random ctl", d, {16'h0, exp_mf(k, c), 15'h01A0 | 15'(cks)});
      check("R9 random irq", {31'b0, irq}, {31'b0, exp_mf(k, c)});
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule